// File: doc/BRIEF.md
# Single-Channel PWM Timer with Atomic Settings Update

The block generates one pulse-width-modulated output from a system clock. A power-of-two prescaler slows the clock into ticks; a 10-bit tick counter sets the period, and a 10-bit on-phase value sets how many ticks of each period the output is high. Software programs it through a 32-bit register bus with two registers: a control register at offset 0x00 and a count register at offset 0x04. Writes are single-cycle strobes and reads are combinational from the selected address.

Every setting exists twice: a shadow copy, which software writes and reads back, and an active copy, which drives the prescaler and counter. Setting the hold bit keeps new divider, period and on-phase values in the shadow copies only. Clearing it transfers all of them together, either at once (channel stopped) or at the next period boundary (channel running), so the waveform never shows a mix of old and new settings. The channel refuses to run while the active period or on-phase is zero.

Top module: `pwm_shadow_timer`

## Requirements
- R1: After reset the output is low and both registers read as zero.
- R2: Control register (offset 0x00): bits 19:16 division field, bit 15 clock mode, bit 11 hold, bit 4 single-shot, bit 0 run. Count register (offset 0x04): bits 25:16 period, bits 9:0 on-phase. Reads return the shadow values; all other bits and all other offsets read as zero.
- R3: The prescaler emits one tick every 2^e clocks, e = 2*division + 1 with clock mode 0 and e = 2*division with clock mode 1, limited to MAX_EXP (24 by default).
- R4: In each period of P ticks the output is high for the first H ticks and low for the rest, H being the on-phase; when H >= P the output is high for the whole period.
- R5: Writing run = 1 has no effect while the active period or active on-phase is zero: the run bit reads back 0 and the output stays low.
- R6: While hold is 1, writes to the count register and to the division field and clock mode change only the shadow copies; the waveform is unaffected.
- R7: Clearing hold while the channel is stopped transfers all shadow settings to the active copies on that same clock edge.
- R8: Clearing hold while the channel runs transfers all shadow settings together at the next period boundary; the old settings stay in force until then.
- R9: With hold at 0, a settings write updates the shadow and active copies on the same clock edge and affects the running waveform at once.
- R10: With single-shot set, the channel runs exactly one period, then clears its run bit and keeps the output low.
- R11: Clearing run drives the output low and clears the prescaler and counter, so the next start begins a fresh period with the output high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | ADDR_W | Byte offset of the register accessed |
| bus_we | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data of the register at bus_addr |
| pwm_out | output | 1 | Pulse-width-modulated output |

## Verification
The bench builds the block with MAX_EXP = 6 and the default 10-bit counter. The small exponent limit makes the saturation of a large division code reachable in a few hundred clocks: code 3 in mode 0 asks for 2^7 but must give 2^6. The full 10-bit width keeps the 1023-tick period and the on-phase-above-period case in range. Hold-bit tests place each write at a known tick of the period, so a transfer made too early or too late shows up in one sampled output level.

// File: rtl/pwm_shadow_pkg.sv
package pwm_shadow_pkg;

  localparam int DIV_W     = 4;
  localparam int OFS_CTRL  = 0;
  localparam int OFS_COUNT = 4;

  localparam int POS_DIV   = 16;
  localparam int POS_MODE  = 15;
  localparam int POS_HOLD  = 11;
  localparam int POS_ONE   = 4;
  localparam int POS_RUN   = 0;
  localparam int POS_PER   = 16;
  localparam int POS_PH    = 0;

  // Exponent of the prescaler: odd steps in mode 0, even steps in mode 1.
  function automatic int unsigned div_exponent(input logic [DIV_W-1:0] code,
                                               input logic mode,
                                               input int unsigned max_exp);
    int unsigned e;
    e = 2 * int'(code) + (mode ? 0 : 1);
    if (e > max_exp) e = max_exp;
    return e;
  endfunction

  // Terminal value of the prescaler for a given exponent.
  function automatic logic [31:0] tick_limit(input int unsigned e);
    return (32'd1 << e) - 32'd1;
  endfunction

endpackage

// File: rtl/pwm_regs.sv
module pwm_regs
  import pwm_shadow_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter int CNT_W  = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_we,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  input  logic              run_q,
  output logic [DIV_W-1:0]  sh_div_nxt,
  output logic              sh_mode_nxt,
  output logic [CNT_W-1:0]  sh_per_nxt,
  output logic [CNT_W-1:0]  sh_ph_nxt,
  output logic              hold_q,
  output logic              oneshot_q,
  output logic              ctrl_wr,
  output logic              wr_run,
  output logic              hold_set,
  output logic              hold_fall,
  output logic              direct_ctrl,
  output logic              direct_cnt
);

  localparam logic [ADDR_W-1:0] A_CTRL  = ADDR_W'(OFS_CTRL);
  localparam logic [ADDR_W-1:0] A_COUNT = ADDR_W'(OFS_COUNT);

  logic [DIV_W-1:0] sh_div_q;
  logic             sh_mode_q;
  logic [CNT_W-1:0] sh_per_q, sh_ph_q;
  logic             cnt_wr, new_hold;
  logic             unused_wdata;

  assign unused_wdata = ^bus_wdata;
  assign ctrl_wr  = bus_we && (bus_addr == A_CTRL);
  assign cnt_wr   = bus_we && (bus_addr == A_COUNT);
  assign new_hold = bus_wdata[POS_HOLD];
  assign wr_run   = bus_wdata[POS_RUN];

  // Events handed to the active copy
  assign hold_set    = ctrl_wr && new_hold;
  assign hold_fall   = ctrl_wr && hold_q && !new_hold;
  assign direct_ctrl = ctrl_wr && !hold_q && !new_hold;
  assign direct_cnt  = cnt_wr && !hold_q;

  always_comb begin
    sh_div_nxt  = sh_div_q;
    sh_mode_nxt = sh_mode_q;
    sh_per_nxt  = sh_per_q;
    sh_ph_nxt   = sh_ph_q;
    if (ctrl_wr) begin
      sh_div_nxt  = bus_wdata[POS_DIV +: DIV_W];
      sh_mode_nxt = bus_wdata[POS_MODE];
    end
    if (cnt_wr) begin
      sh_per_nxt = bus_wdata[POS_PER +: CNT_W];
      sh_ph_nxt  = bus_wdata[POS_PH +: CNT_W];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_div_q  <= '0;
      sh_mode_q <= 1'b0;
      sh_per_q  <= '0;
      sh_ph_q   <= '0;
      hold_q    <= 1'b0;
      oneshot_q <= 1'b0;
    end else begin
      sh_div_q  <= sh_div_nxt;
      sh_mode_q <= sh_mode_nxt;
      sh_per_q  <= sh_per_nxt;
      sh_ph_q   <= sh_ph_nxt;
      if (ctrl_wr) begin
        hold_q    <= new_hold;
        oneshot_q <= bus_wdata[POS_ONE];
      end
    end
  end

  always_comb begin
    bus_rdata = '0;
    if (bus_addr == A_CTRL) begin
      bus_rdata[POS_DIV +: DIV_W] = sh_div_q;
      bus_rdata[POS_MODE]         = sh_mode_q;
      bus_rdata[POS_HOLD]         = hold_q;
      bus_rdata[POS_ONE]          = oneshot_q;
      bus_rdata[POS_RUN]          = run_q;
    end else if (bus_addr == A_COUNT) begin
      bus_rdata[POS_PER +: CNT_W] = sh_per_q;
      bus_rdata[POS_PH +: CNT_W]  = sh_ph_q;
    end
  end

endmodule

// File: rtl/pwm_active.sv
module pwm_active
  import pwm_shadow_pkg::*;
#(
  parameter int CNT_W   = 10,
  parameter int MAX_EXP = 24,
  parameter int EXP_W   = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DIV_W-1:0] sh_div_nxt,
  input  logic             sh_mode_nxt,
  input  logic [CNT_W-1:0] sh_per_nxt,
  input  logic [CNT_W-1:0] sh_ph_nxt,
  input  logic             ctrl_wr,
  input  logic             wr_run,
  input  logic             hold_set,
  input  logic             hold_fall,
  input  logic             direct_ctrl,
  input  logic             direct_cnt,
  input  logic             oneshot_q,
  input  logic             boundary,
  output logic [CNT_W-1:0] ac_per,
  output logic [CNT_W-1:0] ac_ph,
  output logic [EXP_W-1:0] ac_exp,
  output logic             run_q,
  output logic             pend_q,
  output logic             commit_now
);

  logic [CNT_W-1:0] per_d, ph_d;
  logic [EXP_W-1:0] exp_d;
  logic             want_run, run_d, pend_d;

  // Transfer of the whole shadow set: at once when stopped, else at a boundary
  assign commit_now = (hold_fall && !run_q) || (pend_q && (boundary || !run_q));

  always_comb begin
    per_d = ac_per;
    ph_d  = ac_ph;
    exp_d = ac_exp;
    if (commit_now || direct_cnt) begin
      per_d = sh_per_nxt;
      ph_d  = sh_ph_nxt;
    end
    if (commit_now || direct_ctrl)
      exp_d = EXP_W'(div_exponent(sh_div_nxt, sh_mode_nxt, MAX_EXP));
  end

  always_comb begin
    if (hold_set || commit_now)       pend_d = 1'b0;
    else if (hold_fall && run_q)      pend_d = 1'b1;
    else                              pend_d = pend_q;
  end

  always_comb begin
    if (ctrl_wr)                       want_run = wr_run;
    else if (boundary && oneshot_q)    want_run = 1'b0;
    else                               want_run = run_q;
    run_d = want_run && (per_d != '0) && (ph_d != '0);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ac_per <= '0;
      ac_ph  <= '0;
      ac_exp <= '0;
      run_q  <= 1'b0;
      pend_q <= 1'b0;
    end else begin
      ac_per <= per_d;
      ac_ph  <= ph_d;
      ac_exp <= exp_d;
      run_q  <= run_d;
      pend_q <= pend_d;
    end
  end

endmodule

// File: rtl/pwm_wave.sv
module pwm_wave
  import pwm_shadow_pkg::*;
#(
  parameter int CNT_W   = 10,
  parameter int MAX_EXP = 24,
  parameter int EXP_W   = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run_q,
  input  logic [EXP_W-1:0] ac_exp,
  input  logic [CNT_W-1:0] ac_per,
  input  logic [CNT_W-1:0] ac_ph,
  output logic             tick,
  output logic             boundary,
  output logic [CNT_W-1:0] cnt_q,
  output logic             pwm_out
);

  localparam int PRE_W = (MAX_EXP > 0) ? MAX_EXP : 1;

  logic [PRE_W-1:0] pre_q, limit;
  logic             period_end;

  assign limit      = PRE_W'(tick_limit(int'(ac_exp)));
  assign tick       = run_q && (pre_q >= limit);
  assign period_end = (cnt_q >= (ac_per - CNT_W'(1)));
  assign boundary   = tick && period_end;
  assign pwm_out    = run_q && (cnt_q < ac_ph);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_q <= '0;
      cnt_q <= '0;
    end else if (!run_q) begin
      pre_q <= '0;
      cnt_q <= '0;
    end else if (tick) begin
      pre_q <= '0;
      cnt_q <= period_end ? '0 : cnt_q + CNT_W'(1);
    end else begin
      pre_q <= pre_q + PRE_W'(1);
    end
  end

endmodule

// File: rtl/pwm_shadow_timer.sv
module pwm_shadow_timer
  import pwm_shadow_pkg::*;
#(
  parameter int ADDR_W  = 4,
  parameter int CNT_W   = 10,
  parameter int MAX_EXP = 24
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_we,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic              pwm_out
);

  localparam int EXP_W = $clog2(MAX_EXP + 1) + 1;

  logic [DIV_W-1:0] sh_div_nxt;
  logic             sh_mode_nxt;
  logic [CNT_W-1:0] sh_per_nxt, sh_ph_nxt;
  logic             hold_q, oneshot_q, ctrl_wr, wr_run;
  logic             hold_set, hold_fall, direct_ctrl, direct_cnt;
  logic [CNT_W-1:0] ac_per, ac_ph, cnt_q;
  logic [EXP_W-1:0] ac_exp;
  logic             run_q, pend_q, commit_now, tick, boundary;

  pwm_regs #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_regs (
    .clk, .rst_n, .bus_addr, .bus_we, .bus_wdata, .bus_rdata, .run_q,
    .sh_div_nxt, .sh_mode_nxt, .sh_per_nxt, .sh_ph_nxt,
    .hold_q, .oneshot_q, .ctrl_wr, .wr_run,
    .hold_set, .hold_fall, .direct_ctrl, .direct_cnt
  );

  pwm_active #(.CNT_W(CNT_W), .MAX_EXP(MAX_EXP), .EXP_W(EXP_W)) u_active (
    .clk, .rst_n, .sh_div_nxt, .sh_mode_nxt, .sh_per_nxt, .sh_ph_nxt,
    .ctrl_wr, .wr_run, .hold_set, .hold_fall, .direct_ctrl, .direct_cnt,
    .oneshot_q, .boundary, .ac_per, .ac_ph, .ac_exp, .run_q, .pend_q,
    .commit_now
  );

  pwm_wave #(.CNT_W(CNT_W), .MAX_EXP(MAX_EXP), .EXP_W(EXP_W)) u_wave (
    .clk, .rst_n, .run_q, .ac_exp, .ac_per, .ac_ph,
    .tick, .boundary, .cnt_q, .pwm_out
  );

endmodule

// File: rtl/pwm_shadow_timer_chk.sv
module pwm_shadow_timer_chk #(
  parameter int CNT_W = 10,
  parameter int EXP_W = 5
) (
  input logic             clk,
  input logic             rst_n,
  input logic             run_q,
  input logic             pwm_out,
  input logic             hold_q,
  input logic             oneshot_q,
  input logic             ctrl_wr,
  input logic             pend_q,
  input logic             boundary,
  input logic [CNT_W-1:0] ac_per,
  input logic [CNT_W-1:0] ac_ph,
  input logic [EXP_W-1:0] ac_exp,
  input logic [CNT_W-1:0] cnt_q
);

  AST_RUN_NEEDS_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
    run_q |-> (ac_per != '0 && ac_ph != '0)); // R5

  AST_STOPPED_OUT_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    !run_q |-> !pwm_out); // R11

  AST_STOPPED_COUNT_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    !run_q |=> (cnt_q == '0)); // R11

  AST_HOLD_FREEZES_ACTIVE: assert property (@(posedge clk) disable iff (!rst_n)
    (hold_q && !ctrl_wr) |=> ($stable(ac_per) && $stable(ac_ph) && $stable(ac_exp))); // R6

  AST_PENDING_ONLY_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
    pend_q |-> !hold_q); // R8

  AST_ONESHOT_STOPS: assert property (@(posedge clk) disable iff (!rst_n)
    (boundary && oneshot_q && !ctrl_wr) |=> !run_q); // R10

endmodule

bind pwm_shadow_timer pwm_shadow_timer_chk #(.CNT_W(CNT_W), .EXP_W(EXP_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .run_q(run_q), .pwm_out(pwm_out), .hold_q(hold_q),
  .oneshot_q(oneshot_q), .ctrl_wr(ctrl_wr), .pend_q(pend_q), .boundary(boundary),
  .ac_per(ac_per), .ac_ph(ac_ph), .ac_exp(ac_exp), .cnt_q(cnt_q)
);

// File: tb/sim_pwm_shadow_timer.sv
`timescale 1ns/1ps
module sim_pwm_shadow_timer;

  localparam int AW = 4;
  localparam int CW = 10;
  localparam int ME = 6;

  typedef struct packed {
    logic [3:0]  div;
    logic        mode;
    logic [9:0]  per;
    logic [9:0]  ph;
    logic [15:0] win;    // period in clocks: per * 2^e
    logic [15:0] highs;  // high clocks per period: min(ph,per) * 2^e
  } vec_t;

  // e = 2*div+1 (mode 0) or 2*div (mode 1), capped at ME = 6
  localparam vec_t VECS [8] = '{
    '{4'd0, 1'b1, 10'd10,   10'd3,    16'd10,   16'd3},
    '{4'd0, 1'b0, 10'd5,    10'd2,    16'd10,   16'd4},
    '{4'd1, 1'b1, 10'd6,    10'd6,    16'd24,   16'd24},
    '{4'd1, 1'b0, 10'd4,    10'd1,    16'd32,   16'd8},
    '{4'd3, 1'b0, 10'd3,    10'd2,    16'd192,  16'd128},
    '{4'd0, 1'b1, 10'd7,    10'd20,   16'd7,    16'd7},
    '{4'd2, 1'b1, 10'd3,    10'd1,    16'd48,   16'd16},
    '{4'd0, 1'b1, 10'd1023, 10'd1022, 16'd1023, 16'd1022}
  };

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [AW-1:0] addr = '0;
  logic          we = 1'b0;
  logic [31:0]   wdata = '0;
  logic [31:0]   rdata;
  logic          pwm;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  pwm_shadow_timer #(.ADDR_W(AW), .CNT_W(CW), .MAX_EXP(ME)) u0 (
    .clk(clk), .rst_n(rst_n), .bus_addr(addr), .bus_we(we),
    .bus_wdata(wdata), .bus_rdata(rdata), .pwm_out(pwm)
  );

  function automatic logic [31:0] cw(int dv, bit md, bit hd, bit os, bit rn);
    return (32'(dv) << 16) | (32'(md) << 15) | (32'(hd) << 11) | (32'(os) << 4) | 32'(rn);
  endfunction

  function automatic logic [31:0] nw(int per, int ph);
    return (32'(per) << 16) | 32'(ph);
  endfunction

  task automatic chk(string tag, logic [31:0] got, logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, got, exp);
    end
  endtask

  task automatic wr(logic [AW-1:0] a, logic [31:0] d);
    @(negedge clk);
    addr = a; we = 1'b1; wdata = d;
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic rd(logic [AW-1:0] a, output logic [31:0] d);
    addr = a;
    #1;
    d = rdata;
  endtask

  task automatic measure(int n, output int h);
    h = 0;
    for (int i = 0; i < n; i++) begin
      if (pwm) h++;
      @(negedge clk);
    end
  endtask

  task automatic summary();
    $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
  endtask

  initial begin
    #1000000;
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    int h;

    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: reset state
    chk("R1 output", 32'(pwm), 0);
    rd(0, d); chk("R1 control", d, 0);
    rd(4, d); chk("R1 count", d, 0);

    // R2: layout, unused bits, unknown offset
    wr(0, 32'hFFFF_FFFE);
    rd(0, d); chk("R2 control readback", d, 32'h000F_8810);
    wr(4, 32'hFFFF_FFFF);
    rd(4, d); chk("R2 count readback", d, 32'h03FF_03FF);
    rd(8, d); chk("R2 unknown offset", d, 0);
    wr(0, 0);

    // R3/R4: table of divider and waveform settings
    foreach (VECS[k]) begin
      wr(0, 0);
      wr(4, nw(VECS[k].per, VECS[k].ph));
      wr(0, cw(VECS[k].div, VECS[k].mode, 0, 0, 1));
      measure(VECS[k].win, h);
      chk($sformatf("R3/R4 vector %0d first period", k), 32'(h), 32'(VECS[k].highs));
      measure(VECS[k].win, h);
      chk($sformatf("R3/R4 vector %0d second period", k), 32'(h), 32'(VECS[k].highs));
    end

    // R5: refused start with zero period or zero phase
    wr(0, 0);
    wr(4, nw(0, 5));
    wr(0, cw(0, 1, 0, 0, 1));
    rd(0, d); chk("R5 zero period run bit", d, cw(0, 1, 0, 0, 0));
    chk("R5 zero period output", 32'(pwm), 0);
    wr(4, nw(5, 0));
    wr(0, cw(0, 1, 0, 0, 1));
    rd(0, d); chk("R5 zero phase run bit", d, cw(0, 1, 0, 0, 0));

    // R9: direct write with hold low acts at once
    wr(0, 0);
    wr(4, nw(8, 2));
    wr(0, cw(0, 1, 0, 0, 1));     // tick 0
    wr(4, nw(8, 7));              // lands at tick 2
    chk("R9 phase change visible at tick 2", 32'(pwm), 1);

    // R6/R8: held writes, then release while running
    wr(0, 0);
    wr(4, nw(8, 2));
    wr(0, cw(0, 1, 0, 0, 1));     // tick 0
    wr(0, cw(0, 1, 1, 0, 1));     // hold at tick 2
    wr(4, nw(8, 7));              // shadow only, tick 4
    chk("R6 held write leaves waveform", 32'(pwm), 0);
    rd(4, d); chk("R6 shadow readback", d, nw(8, 7));
    wr(0, cw(0, 1, 0, 0, 1));     // release at tick 6
    chk("R8 old phase kept until boundary", 32'(pwm), 0);
    @(negedge clk); @(negedge clk);
    measure(8, h);
    chk("R8 new phase after boundary", 32'(h), 7);

    // R7: release while stopped commits at once
    wr(0, 0);
    wr(0, cw(0, 1, 1, 0, 0));
    wr(4, nw(5, 1));
    wr(0, cw(0, 1, 0, 0, 0));
    wr(0, cw(0, 1, 0, 0, 1));
    measure(5, h);
    chk("R7 committed settings used", 32'(h), 1);

    // R10: single period
    wr(0, 0);
    wr(4, nw(4, 2));
    wr(0, cw(0, 0, 0, 1, 1));     // divide by 2
    measure(8, h);
    chk("R10 one period high time", 32'(h), 4);
    rd(0, d); chk("R10 run bit cleared", d, cw(0, 0, 0, 1, 0));
    measure(16, h);
    chk("R10 output stays low", 32'(h), 0);

    // R11: stop mid-period, restart fresh
    wr(0, 0);
    wr(4, nw(8, 4));
    wr(0, cw(0, 1, 0, 0, 1));
    repeat (3) @(negedge clk);
    wr(0, cw(0, 1, 0, 0, 0));     // stop at tick 5
    chk("R11 output low when stopped", 32'(pwm), 0);
    wr(0, cw(0, 1, 0, 0, 1));
    measure(4, h);
    chk("R11 fresh period starts high", 32'(h), 4);
    measure(4, h);
    chk("R11 fresh period low part", 32'(h), 0);

    done = 1'b1;
    summary();
    $finish;
  end

endmodule